// File: doc/BRIEF.md
# Pad Signal Routing Matrix

This block is a register-programmed crossbar that sits between a bank of general-purpose I/O pads and the peripherals inside a chip. Every pad owns two configuration words. One chooses which internal signal drives the pad's output value. The other chooses which internal signal drives the pad's output enable. The internal source set contains a constant-0 line and a constant-1 line, so the same words serve for peripheral pin multiplexing and for direct software control of a pad. Each of the two words also has an invert flag that flips the chosen signal on its way to the pad.

In the other direction, every peripheral input has its own select word naming the pad that feeds it, and one reserved code leaves the input unconnected. Pad levels pass through a synchronizer before they are routed inward or read back, and software can read the synchronized levels of all pads as packed 32-bit words. Configuration goes through a simple synchronous word bus. Read data is registered and appears one cycle after the address.

Top module: `padroute_matrix`

## Requirements
- R1: After reset every pad output and output enable is 0, every peripheral input is 0, and every input select word reads 0x000000FF.
- R2: The pad output word of pad p is at byte address 0x100+8p, and its bits [7:0] pick the source that drives pad_out[p]. Source 0 is constant 0, source 1 is constant 1, source k in 2..63 is core_sig[k-2], and any source code of 64 or more gives constant 0.
- R3: The output-enable word of pad p is at byte address 0x104+8p. Its bits [7:0] pick a source from the same set, and that source drives pad_oe[p], where 1 means the pad driver is on.
- R4: Bit 31 of a pad output or output-enable word inverts the chosen source before it reaches the pad.
- R5: The input select word of peripheral input i is at byte address 0x300+4i. Its bits [7:0] name the pad that drives core_in[i]. Code 0xFF, and any pad number of 64 or more, gives 0.
- R6: A change on pad_in reaches core_in and the level readback after exactly two rising clock edges.
- R7: The synchronized levels of pads 0 to 31 read at 0x048 and those of pads 32 to 63 at 0x04C, with pad n at bit n mod 32. Writes to these words have no effect.
- R8: A configuration word reads back with its select in bits [7:0] and, for pad words, its invert flag in bit 31. All other bits read 0, and so does every unmapped address. bus_rdata holds the value for the address presented at the previous rising edge.
- R9: A write changes only the word it addresses. The routing of every other pad and input is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the configuration bus |
| bus_addr | input | 12 | Byte address; bits [1:0] ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous address |
| core_sig | input | 62 | Internal signals selectable as pad sources 2..63 |
| core_in | output | 32 | Routed pad levels toward peripheral inputs |
| pad_in | input | 64 | Raw pad input levels |
| pad_out | output | 64 | Pad output values |
| pad_oe | output | 64 | Pad output enables, 1 = driving |

## Verification
A wrong stored select or invert flag shows up on pad_out or pad_oe in the cycle right after the write, as long as the chosen source differs from the correct one. The bench varies core_sig on every cycle so that this difference appears within a few cycles. A fault in the inward path shows on core_in two edges after the pad changes, and a decode fault that hits a neighbouring word shows on that neighbour's output in the same cycle. Readback faults appear on bus_rdata one cycle after the address. All four outputs are compared against a behavioural model on every clock.

// File: rtl/padroute_pkg.sv
package padroute_pkg;

   localparam int          SEL_W    = 8;
   localparam int          SEL_SPAN = 2 ** SEL_W;
   localparam logic [7:0]  SEL_NONE = 8'hFF;

   // one routing choice for a pad-side signal
   typedef struct packed {
      logic             inv;
      logic [SEL_W-1:0] sel;
   } route_sel_t;

   localparam route_sel_t ROUTE_RESET = '{inv: 1'b0, sel: '0};

   function automatic logic [31:0] pack_route(route_sel_t r);
      return {r.inv, 23'b0, r.sel};
   endfunction

   function automatic route_sel_t unpack_route(logic [31:0] w);
      return '{inv: w[31], sel: w[SEL_W-1:0]};
   endfunction

endpackage

// File: rtl/padroute_regs.sv
module padroute_regs
   import padroute_pkg::*;
#(
   parameter int NUM_PADS    = 64,
   parameter int NUM_CORE_IN = 32,
   parameter int ADDR_W      = 12,
   parameter int PAD_BASE    = 'h100,
   parameter int IN_BASE     = 'h300,
   parameter int DIN_BASE    = 'h048
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              bus_wr,
   input  logic [ADDR_W-1:0]                 bus_addr,
   input  logic [31:0]                       bus_wdata,
   output logic [31:0]                       bus_rdata,
   input  logic [NUM_PADS-1:0]               din_raw,
   output route_sel_t [NUM_PADS-1:0]         out_cfg,
   output route_sel_t [NUM_PADS-1:0]         oe_cfg,
   output logic [NUM_CORE_IN-1:0][SEL_W-1:0] in_cfg
);

   localparam int DIN_WORDS = NUM_PADS / 32;
   localparam int WA_W      = ADDR_W - 2;

   logic [WA_W-1:0]        word_addr;
   logic [NUM_PADS-1:0]    hit_out;
   logic [NUM_PADS-1:0]    hit_oe;
   logic [NUM_CORE_IN-1:0] hit_in;
   logic [DIN_WORDS-1:0]   hit_din;
   logic [31:0]            rd_next;
   logic                   unused_bits;

   assign word_addr   = bus_addr[ADDR_W-1:2];
   assign unused_bits = ^{bus_addr[1:0], bus_wdata[30:SEL_W]};

   // per-pad route words
   for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
      localparam logic [ADDR_W-1:0] A_OUT = ADDR_W'(PAD_BASE + 8 * p);
      localparam logic [ADDR_W-1:0] A_OE  = ADDR_W'(PAD_BASE + 8 * p + 4);

      assign hit_out[p] = (word_addr == A_OUT[ADDR_W-1:2]);
      assign hit_oe[p]  = (word_addr == A_OE[ADDR_W-1:2]);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            out_cfg[p] <= ROUTE_RESET;
            oe_cfg[p]  <= ROUTE_RESET;
         end else if (bus_wr) begin
            if (hit_out[p]) out_cfg[p] <= unpack_route(bus_wdata);
            if (hit_oe[p])  oe_cfg[p]  <= unpack_route(bus_wdata);
         end
      end
   end

   // per-peripheral-input pad selects
   for (genvar i = 0; i < NUM_CORE_IN; i++) begin : g_in
      localparam logic [ADDR_W-1:0] A_IN = ADDR_W'(IN_BASE + 4 * i);

      assign hit_in[i] = (word_addr == A_IN[ADDR_W-1:2]);

      always_ff @(posedge clk) begin
         if (!rst_n)
            in_cfg[i] <= SEL_NONE;
         else if (bus_wr && hit_in[i])
            in_cfg[i] <= bus_wdata[SEL_W-1:0];
      end

      // R8: a write to an input select lands in that word on the next edge
      p_in_write_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_wr && hit_in[i]) |=> (in_cfg[i] == $past(bus_wdata[SEL_W-1:0])));
   end

   // read-only level view words
   for (genvar w = 0; w < DIN_WORDS; w++) begin : g_din
      localparam logic [ADDR_W-1:0] A_DIN = ADDR_W'(DIN_BASE + 4 * w);
      assign hit_din[w] = (word_addr == A_DIN[ADDR_W-1:2]);
   end

   always_comb begin
      rd_next = '0;
      for (int p = 0; p < NUM_PADS; p++) begin
         if (hit_out[p]) rd_next = pack_route(out_cfg[p]);
         if (hit_oe[p])  rd_next = pack_route(oe_cfg[p]);
      end
      for (int i = 0; i < NUM_CORE_IN; i++)
         if (hit_in[i]) rd_next = {24'b0, in_cfg[i]};
      for (int w = 0; w < DIN_WORDS; w++)
         if (hit_din[w]) rd_next = din_raw[32*w +: 32];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) bus_rdata <= '0;
      else        bus_rdata <= rd_next;
   end

   // R8: at most one word decodes for any address
   p_single_decode_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({hit_out, hit_oe, hit_in, hit_din}));

endmodule

// File: rtl/padroute_outsel.sv
module padroute_outsel
   import padroute_pkg::*;
#(
   parameter int NUM_PADS     = 64,
   parameter int NUM_CORE_SIG = 62,
   parameter bit REGISTER_OUT = 1'b0
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_CORE_SIG-1:0]   core_sig,
   input  route_sel_t [NUM_PADS-1:0] out_cfg,
   input  route_sel_t [NUM_PADS-1:0] oe_cfg,
   output logic [NUM_PADS-1:0]       pad_out,
   output logic [NUM_PADS-1:0]       pad_oe
);

   localparam int NUM_SRC = NUM_CORE_SIG + 2;

   // source 0 = constant 0, source 1 = constant 1, then core signals
   logic [SEL_SPAN-1:0] src_ext;
   logic [NUM_PADS-1:0] out_c;
   logic [NUM_PADS-1:0] oe_c;

   assign src_ext = SEL_SPAN'({core_sig, 1'b1, 1'b0});

   for (genvar p = 0; p < NUM_PADS; p++) begin : g_mux
      assign out_c[p] = src_ext[out_cfg[p].sel] ^ out_cfg[p].inv;
      assign oe_c[p]  = src_ext[oe_cfg[p].sel]  ^ oe_cfg[p].inv;

      // R2: a source code beyond the source set behaves as constant 0
      p_oor_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (int'(out_cfg[p].sel) >= NUM_SRC) |-> (out_c[p] == out_cfg[p].inv));
   end

   if (REGISTER_OUT) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pad_out <= '0;
            pad_oe  <= '0;
         end else begin
            pad_out <= out_c;
            pad_oe  <= oe_c;
         end
      end
   end else begin : g_comb
      assign pad_out = out_c;
      assign pad_oe  = oe_c;
   end

endmodule

// File: rtl/padroute_insel.sv
module padroute_insel
   import padroute_pkg::*;
#(
   parameter int NUM_PADS    = 64,
   parameter int NUM_CORE_IN = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [NUM_PADS-1:0]               pad_in,
   input  logic [NUM_CORE_IN-1:0][SEL_W-1:0] in_cfg,
   output logic [NUM_PADS-1:0]               pad_sync,
   output logic [NUM_CORE_IN-1:0]            core_in
);

   logic [NUM_PADS-1:0] stage [SYNC_STAGES];
   logic [SEL_SPAN-1:0] pad_ext;

   always_ff @(posedge clk) begin
      if (!rst_n) stage[0] <= '0;
      else        stage[0] <= pad_in;
   end

   for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk) begin
         if (!rst_n) stage[s] <= '0;
         else        stage[s] <= stage[s-1];
      end
   end

   assign pad_sync = stage[SYNC_STAGES-1];
   assign pad_ext  = SEL_SPAN'(pad_sync);

   for (genvar i = 0; i < NUM_CORE_IN; i++) begin : g_route
      assign core_in[i] = (in_cfg[i] == SEL_NONE) ? 1'b0 : pad_ext[in_cfg[i]];
   end

   if (SYNC_STAGES == 2) begin : g_chk
      logic [1:0] up_cnt;
      always_ff @(posedge clk) begin
         if (!rst_n)          up_cnt <= '0;
         else if (up_cnt < 2) up_cnt <= up_cnt + 2'd1;
      end
      // R6: the level view equals pad_in two edges earlier
      p_sync_delay_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (up_cnt == 2'd2) |-> (pad_sync == $past(pad_in, 2)));
   end

endmodule

// File: rtl/padroute_matrix.sv
module padroute_matrix
   import padroute_pkg::*;
#(
   parameter int NUM_PADS     = 64,
   parameter int NUM_CORE_SIG = 62,
   parameter int NUM_CORE_IN  = 32,
   parameter int SYNC_STAGES  = 2,
   parameter bit REGISTER_OUT = 1'b0,
   parameter int ADDR_W       = 12,
   parameter int PAD_BASE     = 'h100,
   parameter int IN_BASE      = 'h300,
   parameter int DIN_BASE     = 'h048
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    bus_wr,
   input  logic [ADDR_W-1:0]       bus_addr,
   input  logic [31:0]             bus_wdata,
   output logic [31:0]             bus_rdata,
   input  logic [NUM_CORE_SIG-1:0] core_sig,
   output logic [NUM_CORE_IN-1:0]  core_in,
   input  logic [NUM_PADS-1:0]     pad_in,
   output logic [NUM_PADS-1:0]     pad_out,
   output logic [NUM_PADS-1:0]     pad_oe
);

   localparam int PAD_SPAN = 8 * NUM_PADS;
   localparam int IN_SPAN  = 4 * NUM_CORE_IN;
   localparam int DIN_SPAN = NUM_PADS / 8;

   // elaboration-time parameter checks
   if (NUM_PADS % 32 != 0 || NUM_PADS < 32 || NUM_PADS > 255) begin : g_bad_pads
      $error("NUM_PADS must be a multiple of 32 below 255");
   end
   if (NUM_CORE_SIG + 2 > SEL_SPAN || NUM_CORE_SIG < 1) begin : g_bad_src
      $error("NUM_CORE_SIG does not fit the source selector");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (PAD_BASE + PAD_SPAN > IN_BASE || IN_BASE + IN_SPAN > 2 ** ADDR_W
       || DIN_BASE + DIN_SPAN > PAD_BASE) begin : g_bad_map
      $error("register regions overlap or exceed the address space");
   end

   route_sel_t [NUM_PADS-1:0]         out_cfg;
   route_sel_t [NUM_PADS-1:0]         oe_cfg;
   logic [NUM_CORE_IN-1:0][SEL_W-1:0] in_cfg;
   logic [NUM_PADS-1:0]               pad_sync;

   padroute_regs #(
      .NUM_PADS(NUM_PADS), .NUM_CORE_IN(NUM_CORE_IN), .ADDR_W(ADDR_W),
      .PAD_BASE(PAD_BASE), .IN_BASE(IN_BASE), .DIN_BASE(DIN_BASE)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .din_raw(pad_sync),
      .out_cfg(out_cfg), .oe_cfg(oe_cfg), .in_cfg(in_cfg)
   );

   padroute_outsel #(
      .NUM_PADS(NUM_PADS), .NUM_CORE_SIG(NUM_CORE_SIG), .REGISTER_OUT(REGISTER_OUT)
   ) u_outsel (
      .clk(clk), .rst_n(rst_n), .core_sig(core_sig), .out_cfg(out_cfg),
      .oe_cfg(oe_cfg), .pad_out(pad_out), .pad_oe(pad_oe)
   );

   padroute_insel #(
      .NUM_PADS(NUM_PADS), .NUM_CORE_IN(NUM_CORE_IN), .SYNC_STAGES(SYNC_STAGES)
   ) u_insel (
      .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .in_cfg(in_cfg),
      .pad_sync(pad_sync), .core_in(core_in)
   );

   // R1: the first cycle out of reset shows the quiet state at the ports
   p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (pad_oe == '0 && pad_out == '0 && core_in == '0));

   if (!REGISTER_OUT) begin : g_pad_chk
      for (genvar p = 0; p < NUM_PADS; p++) begin : g_p
         localparam logic [ADDR_W-1:0] A_OUT = ADDR_W'(PAD_BASE + 8 * p);
         localparam logic [ADDR_W-1:0] A_OE  = ADDR_W'(PAD_BASE + 8 * p + 4);
         // R2: selecting the constant-1 source drives the pad high next cycle
         p_const_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr[ADDR_W-1:2] == A_OUT[ADDR_W-1:2]
             && bus_wdata == 32'h0000_0001) |=> pad_out[p]);
         // R4: inverted constant 0 on the enable turns the driver on
         p_oe_invert_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr[ADDR_W-1:2] == A_OE[ADDR_W-1:2]
             && bus_wdata == 32'h8000_0000) |=> pad_oe[p]);
      end
   end

   for (genvar i = 0; i < NUM_CORE_IN; i++) begin : g_in_chk
      localparam logic [ADDR_W-1:0] A_IN = ADDR_W'(IN_BASE + 4 * i);
      // R5: the no-pad code forces the peripheral input low next cycle
      p_no_pad_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_wr && bus_addr[ADDR_W-1:2] == A_IN[ADDR_W-1:2]
          && bus_wdata[SEL_W-1:0] == SEL_NONE) |=> !core_in[i]);
   end

endmodule

// File: tb/padroute_matrix_test.sv
module padroute_matrix_test;

   localparam int NP = 64;
   localparam int NS = 62;
   localparam int NI = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0;
   logic [11:0]   bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NS-1:0] core_sig = '0;
   logic [NI-1:0] core_in;
   logic [NP-1:0] pad_in = '0;
   logic [NP-1:0] pad_out;
   logic [NP-1:0] pad_oe;

   int  n_tests = 0;
   int  n_fail  = 0;
   bit  rand_en = 1'b0;
   bit  done    = 1'b0;

   always #2 clk = ~clk;

   padroute_matrix uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .core_sig(core_sig),
      .core_in(core_in), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
   );

   // ---------------- behavioural reference model ----------------
   int          m_out_sel [NP];
   bit          m_out_inv [NP];
   int          m_oe_sel  [NP];
   bit          m_oe_inv  [NP];
   int          m_in_sel  [NI];
   logic [NP-1:0] m_q1, m_q2;
   logic [31:0]   m_rdata;

   function automatic logic [31:0] m_read(logic [11:0] a);
      int w;
      w = int'(a) / 4;
      if (w >= 'h40 && w < 'hC0) begin
         int p;
         p = (w - 'h40) / 2;
         if (w % 2 == 1) return {m_oe_inv[p], 23'b0, 8'(m_oe_sel[p])};
         return {m_out_inv[p], 23'b0, 8'(m_out_sel[p])};
      end
      if (w >= 'hC0 && w < 'hC0 + NI) return {24'b0, 8'(m_in_sel[w - 'hC0])};
      if (w == 'h12) return m_q2[31:0];
      if (w == 'h13) return m_q2[63:32];
      return 32'b0;
   endfunction

   function automatic logic m_src(int k);
      if (k == 0) return 1'b0;
      if (k == 1) return 1'b1;
      if (k < NS + 2) return core_sig[k-2];
      return 1'b0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int p = 0; p < NP; p++) begin
            m_out_sel[p] = 0; m_out_inv[p] = 0; m_oe_sel[p] = 0; m_oe_inv[p] = 0;
         end
         for (int i = 0; i < NI; i++) m_in_sel[i] = 255;
         m_q1 = '0; m_q2 = '0; m_rdata = '0;
      end else begin
         int w;
         m_rdata = m_read(bus_addr);
         w = int'(bus_addr) / 4;
         if (bus_wr) begin
            if (w >= 'h40 && w < 'hC0) begin
               if (w % 2 == 1) begin
                  m_oe_sel[(w-'h40)/2] = int'(bus_wdata[7:0]);
                  m_oe_inv[(w-'h40)/2] = bus_wdata[31];
               end else begin
                  m_out_sel[(w-'h40)/2] = int'(bus_wdata[7:0]);
                  m_out_inv[(w-'h40)/2] = bus_wdata[31];
               end
            end else if (w >= 'hC0 && w < 'hC0 + NI)
               m_in_sel[w-'hC0] = int'(bus_wdata[7:0]);
         end
         m_q2 = m_q1;
         m_q1 = pad_in;
      end
   end

   task automatic check(input bit ok, input string tag, input logic [63:0] act,
                        input logic [63:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // compare every port against the model each cycle
   always @(posedge clk) begin
      #1;
      if (rst_n && !done) begin
         logic [NP-1:0] e_out, e_oe;
         logic [NI-1:0] e_in;
         for (int p = 0; p < NP; p++) begin
            e_out[p] = m_src(m_out_sel[p]) ^ m_out_inv[p];
            e_oe[p]  = m_src(m_oe_sel[p])  ^ m_oe_inv[p];
         end
         for (int i = 0; i < NI; i++)
            e_in[i] = (m_in_sel[i] < NP) ? m_q2[m_in_sel[i]] : 1'b0;
         check(pad_out === e_out, "R2/R4/R9 pad_out", pad_out, e_out);
         check(pad_oe === e_oe, "R3/R4/R9 pad_oe", pad_oe, e_oe);
         check(core_in === e_in, "R5/R6 core_in", 64'(core_in), 64'(e_in));
         check(bus_rdata === m_rdata, "R7/R8 bus_rdata", 64'(bus_rdata), 64'(m_rdata));
      end
   end

   always @(negedge clk) begin
      if (rand_en) begin
         core_sig <= {$urandom, $urandom};
         pad_in   <= {$urandom, $urandom};
      end
   end

   task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      @(posedge clk);
      #1 d = bus_rdata;
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         done = 1'b1;
         n_tests++; n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] rd;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); #1;
      check(pad_oe === '0, "R1 pad_oe after reset", pad_oe, '0);
      check(pad_out === '0, "R1 pad_out after reset", pad_out, '0);
      check(core_in === '0, "R1 core_in after reset", 64'(core_in), 0);
      bus_read(12'h300, rd);
      check(rd === 32'hFF, "R1 input select reset", 64'(rd), 64'hFF);
      bus_read(12'h37C, rd);
      check(rd === 32'hFF, "R1 last input select reset", 64'(rd), 64'hFF);

      // R2 constant one, R3 enable on via constant one
      bus_write(12'h100 + 12'(8*5), 32'h1);
      bus_write(12'h104 + 12'(8*5), 32'h1);
      @(posedge clk); #1;
      check(pad_out[5] === 1'b1 && pad_oe[5] === 1'b1, "R2/R3 pad5 const1",
            {pad_out[5], pad_oe[5]}, 2'b11);
      // R4 invert of constant 0
      bus_write(12'h100 + 12'(8*9), 32'h8000_0000);
      @(posedge clk); #1;
      check(pad_out[9] === 1'b1, "R4 invert const0", 64'(pad_out[9]), 1);
      // R2 out-of-range code 64 gives 0
      bus_write(12'h100 + 12'(8*9), 32'h0000_0040);
      @(posedge clk); #1;
      check(pad_out[9] === 1'b0, "R2 code 64 is zero", 64'(pad_out[9]), 0);
      // R8 readback masks unused bits
      bus_write(12'h104 + 12'(8*63), 32'hFFFF_FF3F);
      bus_read(12'h104 + 12'(8*63), rd);
      check(rd === 32'h8000_003F, "R8 masked readback", 64'(rd), 64'h8000_003F);
      bus_read(12'h050, rd);
      check(rd === 32'h0, "R8 unmapped reads zero", 64'(rd), 0);

      // R6 two-edge latency on pad 63 into input 3
      bus_write(12'h300 + 12'(4*3), 32'd63);
      @(negedge clk); pad_in[63] = 1'b1;
      @(posedge clk); #1;
      check(core_in[3] === 1'b0, "R6 not after one edge", 64'(core_in[3]), 0);
      @(posedge clk); #1;
      check(core_in[3] === 1'b1, "R6 after two edges", 64'(core_in[3]), 1);
      // R5 back to no pad
      bus_write(12'h300 + 12'(4*3), 32'hFF);
      @(posedge clk); #1;
      check(core_in[3] === 1'b0, "R5 code FF gives 0", 64'(core_in[3]), 0);
      // R7 level word is read-only
      bus_write(12'h04C, 32'h0);
      bus_read(12'h04C, rd);
      check(rd[31] === 1'b1, "R7 pad63 level after write", 64'(rd[31]), 1);

      // random phase, checked every cycle against the model
      rand_en = 1'b1;
      for (int n = 0; n < 1500; n++) begin
         logic [11:0] a;
         logic [31:0] d;
         int r;
         r = $urandom_range(0, 9);
         if (r < 5)      a = 12'h100 + 12'(4 * $urandom_range(0, 127));
         else if (r < 7) a = 12'h300 + 12'(4 * $urandom_range(0, NI-1));
         else if (r < 8) a = ($urandom_range(0, 1) == 1) ? 12'h048 : 12'h04C;
         else            a = 12'(4 * $urandom_range(0, 1023));
         d = $urandom;
         if ($urandom_range(0, 3) != 0) d[7:0] = 8'($urandom_range(0, 70));
         if ($urandom_range(0, 1) == 1) bus_write(a, d);
         else                           bus_read(a, rd);
      end
      rand_en = 1'b0;
      repeat (4) @(negedge clk);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule